// File: doc/BRIEF.md
# Stride prefetch address generator

This block watches a stream of training accesses, each tagged with the program counter of the issuing instruction, a requestor identifier and a byte address. It remembers, per instruction stream, the last address seen, the last address difference and a small saturating confidence count. These are kept in a set-associative history table selected by the low program-counter bits. When a stream shows a steady stride with enough confidence, the block produces a short burst of line-aligned prefetch addresses ahead of the demand stream, one per cycle on a valid/ready output.

A parameter selects how many strides past the triggering address the burst begins. Another sets the burst length. Strides shorter than a cache line are widened to exactly one line in the same direction, so that every prefetch targets a different line. While a burst is pending or stalled, the training input is held off, so the table and the burst state never change under a waiting output.

Top module: `stride_prefetch_gen`

## Requirements
- R1: After reset, pf_valid is 0, train_ready is 1 and every table entry is empty, so the first access of any stream is a miss.
- R2: On a table hit, the observed stride is train_addr minus the stored last address, modulo 2^ADDR_W. If it equals the stored stride, the confidence counter (0 to 2^CONF_BITS-1) saturates upward. A burst starts only when the updated count is at least ceil((2^CONF_BITS-1)*THRESH_PCT/100). With a 2-bit counter and 50 %, the threshold is 2, so the fourth access of a constant-stride stream is the first to trigger.
- R3: On a miss, an entry is allocated with the access address, a stride of zero and a confidence of zero, and no prefetch is issued.
- R4: On a hit whose observed stride differs from the stored one, the confidence counter decrements (saturating at zero), and the stored stride becomes the observed one. The burst rule of R2 then applies with the new stride.
- R5: An observed stride of zero never starts a burst, whatever the confidence.
- R6: The effective stride equals the observed stride when its magnitude is at least LINE_BYTES. Otherwise it is +LINE_BYTES or -LINE_BYTES, following the sign of the observed stride.
- R7: Prefetch k (k = 1..DEGREE) is (T + (DISTANCE + k) * E) modulo 2^ADDR_W, with the low log2(LINE_BYTES) bits cleared. Here T is the triggering address and E the effective stride.
- R8: A burst presents exactly DEGREE addresses in increasing k, advancing on each cycle with pf_valid and pf_ready both high. pf_valid drops the cycle after the last handshake and never rises without an accepted training access.
- R9: While pf_valid is high, train_ready is 0, pf_addr holds its value across stalled cycles, and an offered training access has no effect on the table.
- R10: With USE_RID set, an entry matches only when both the program counter and the requestor identifier are equal. With it clear, the identifier is ignored.
- R11: The set index is the low log2(ENTRIES/WAYS) bits of train_pc. On a miss the lowest-numbered empty way of the set is filled first; otherwise the victim is chosen by a binary-tree pseudo-LRU whose bits point away from the most recently accessed way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| train_valid | input | 1 | Training access offered |
| train_ready | output | 1 | Training access can be taken (no burst pending) |
| train_pc | input | PC_W | Program counter of the access |
| train_rid | input | RID_W | Requestor identifier of the access |
| train_addr | input | ADDR_W | Byte address of the access |
| pf_valid | output | 1 | Prefetch address valid |
| pf_ready | input | 1 | Prefetch address taken |
| pf_addr | output | ADDR_W | Line-aligned prefetch address |

## Verification
The hardest situation to reach from the ports is an eviction of a confident entry by the pseudo-LRU. The table state cannot be seen directly, so the loss of history must show up as a missing burst. The bench therefore resets, trains one stream to confidence and fills the other ways of its set in a known order. It then allocates one more stream into the same set and replays the first stream's next address, where a retained entry would have fired. A second hard case is a training access offered during a stalled burst. The bench holds a conflicting access on the input throughout the burst and confirms that the next genuine access still triggers as if nothing had been offered.

// File: rtl/stride_prefetch_gen.sv
module stride_prefetch_gen #(
  parameter int ADDR_W     = 32,
  parameter int PC_W       = 16,
  parameter int RID_W      = 4,
  parameter int LINE_BYTES = 64,
  parameter int ENTRIES    = 64,
  parameter int WAYS       = 4,
  parameter int DEGREE     = 4,
  parameter int DISTANCE   = 0,
  parameter int CONF_BITS  = 2,
  parameter int THRESH_PCT = 50,
  parameter bit USE_RID    = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              train_valid,
  output logic              train_ready,
  input  logic [PC_W-1:0]   train_pc,
  input  logic [RID_W-1:0]  train_rid,
  input  logic [ADDR_W-1:0] train_addr,
  output logic              pf_valid,
  input  logic              pf_ready,
  output logic [ADDR_W-1:0] pf_addr
);
  localparam int SETS     = ENTRIES / WAYS;
  localparam int IDX_W    = (SETS > 1) ? $clog2(SETS) : 1;
  localparam int LVL      = $clog2(WAYS);
  localparam int KEY_W    = PC_W + RID_W;
  localparam int OFF_W    = $clog2(LINE_BYTES);
  localparam int CONF_MAX = (1 << CONF_BITS) - 1;
  localparam int THRESH   = (CONF_MAX * THRESH_PCT + 99) / 100;
  localparam int CNT_W    = $clog2(DEGREE + 1);

  logic                 v_q     [SETS][WAYS];
  logic [KEY_W-1:0]     key_q   [SETS][WAYS];
  logic [ADDR_W-1:0]    last_q  [SETS][WAYS];
  logic [ADDR_W-1:0]    stride_q[SETS][WAYS];
  logic [CONF_BITS-1:0] conf_q  [SETS][WAYS];
  logic [WAYS-2:0]      plru_q  [SETS];

  logic              busy;
  logic [CNT_W-1:0]  cnt;
  logic [ADDR_W-1:0] cur, step;

  logic [KEY_W-1:0]     key;
  logic [IDX_W-1:0]     idx;
  logic                 hit, has_inv;
  logic [LVL-1:0]       hit_way, inv_way, plru_way, sel_way;
  logic [WAYS-2:0]      plru_nx;
  logic [ADDR_W-1:0]    obs, mag, eff, start;
  logic [CONF_BITS-1:0] conf_old, conf_nx;
  logic                 match, fire, acc;

  assign key = {train_pc, USE_RID ? train_rid : {RID_W{1'b0}}};
  assign idx = (SETS > 1) ? IDX_W'(train_pc) : '0;
  assign acc = train_valid && train_ready;

  always_comb begin : lookup
    int nd;
    hit = 1'b0; hit_way = '0; has_inv = 1'b0; inv_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!v_q[idx][w]) begin
        has_inv = 1'b1;
        inv_way = LVL'(w);
      end
      if (v_q[idx][w] && key_q[idx][w] == key) begin
        hit = 1'b1;
        hit_way = LVL'(w);
      end
    end
    plru_way = '0;
    nd = 0;
    for (int l = 0; l < LVL; l++) begin
      plru_way[LVL-1-l] = plru_q[idx][nd];
      nd = 2 * nd + 1 + int'(plru_q[idx][nd]);
    end
    sel_way = hit ? hit_way : (has_inv ? inv_way : plru_way);
    plru_nx = plru_q[idx];
    nd = 0;
    for (int l = 0; l < LVL; l++) begin
      plru_nx[nd] = ~sel_way[LVL-1-l];
      nd = 2 * nd + 1 + int'(sel_way[LVL-1-l]);
    end
  end

  assign obs      = train_addr - last_q[idx][hit_way];
  assign match    = obs == stride_q[idx][hit_way];
  assign conf_old = conf_q[idx][hit_way];

  always_comb begin
    if (match) conf_nx = (conf_old == CONF_BITS'(CONF_MAX)) ? conf_old : conf_old + 1'b1;
    else       conf_nx = (conf_old == '0) ? conf_old : conf_old - 1'b1;
  end

  assign fire  = hit && (conf_nx >= CONF_BITS'(THRESH)) && (obs != '0);
  assign mag   = obs[ADDR_W-1] ? -obs : obs;
  assign eff   = (mag < ADDR_W'(LINE_BYTES))
               ? (obs[ADDR_W-1] ? -ADDR_W'(LINE_BYTES) : ADDR_W'(LINE_BYTES))
               : obs;
  assign start = train_addr + eff * ADDR_W'(DISTANCE + 1);

  assign train_ready = !busy;
  assign pf_valid    = busy;
  assign pf_addr     = {cur[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        plru_q[s] <= '0;
        for (int w = 0; w < WAYS; w++) begin
          v_q[s][w]      <= 1'b0;
          key_q[s][w]    <= '0;
          last_q[s][w]   <= '0;
          stride_q[s][w] <= '0;
          conf_q[s][w]   <= '0;
        end
      end
      busy <= 1'b0;
      cnt  <= '0;
      cur  <= '0;
      step <= '0;
    end else begin
      if (acc) begin
        plru_q[idx] <= plru_nx;
        last_q[idx][sel_way] <= train_addr;
        if (hit) begin
          stride_q[idx][sel_way] <= obs;
          conf_q[idx][sel_way]   <= conf_nx;
        end else begin
          v_q[idx][sel_way]      <= 1'b1;
          key_q[idx][sel_way]    <= key;
          stride_q[idx][sel_way] <= '0;
          conf_q[idx][sel_way]   <= '0;
        end
        if (fire) begin
          busy <= 1'b1;
          cnt  <= CNT_W'(DEGREE);
          cur  <= start;
          step <= eff;
        end
      end
      if (busy && pf_ready) begin
        cur <= cur + step;
        cnt <= cnt - 1'b1;
        if (cnt == CNT_W'(1)) busy <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/stride_prefetch_gen_chk.sv
module stride_prefetch_gen_chk #(
  parameter int ADDR_W = 32,
  parameter int DEGREE = 4
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         train_valid,
  input logic                         train_ready,
  input logic                         pf_valid,
  input logic                         pf_ready,
  input logic [ADDR_W-1:0]            pf_addr,
  input logic [$clog2(DEGREE+1)-1:0]  cnt
);
  localparam int CNT_W = $clog2(DEGREE + 1);

  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pf_valid && !pf_ready |=> pf_valid && $stable(pf_addr));

  // R8
  no_spurious_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pf_valid && !(train_valid && train_ready) |=> !pf_valid);

  // R8
  burst_count_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pf_valid |-> (cnt >= CNT_W'(1)) && (cnt <= CNT_W'(DEGREE)));

  // R8
  burst_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pf_valid && pf_ready && cnt == CNT_W'(1) |=> !pf_valid);

  // R8
  burst_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pf_valid && pf_ready && cnt > CNT_W'(1) |=> pf_valid && cnt == $past(cnt) - 1'b1);
endmodule

bind stride_prefetch_gen stride_prefetch_gen_chk #(.ADDR_W(ADDR_W), .DEGREE(DEGREE)) u_chk (
  .clk(clk), .rst_n(rst_n), .train_valid(train_valid), .train_ready(train_ready),
  .pf_valid(pf_valid), .pf_ready(pf_ready), .pf_addr(pf_addr), .cnt(cnt)
);

// File: tb/sim_stride_prefetch_gen.sv
module sim_stride_prefetch_gen;
  localparam int PERIOD = 10;
  localparam int AW = 16, DEG = 3, DIST = 2, LINE = 16;

  logic clk = 0, rst_n = 0;
  logic train_valid = 0, train_ready, pf_valid, pf_ready = 0;
  logic [7:0]  train_pc = 0;
  logic [1:0]  train_rid = 0;
  logic [AW-1:0] train_addr = 0, pf_addr;
  int checks = 0, fails = 0, pat = 0;

  always #(PERIOD/2) clk = ~clk;

  stride_prefetch_gen #(.ADDR_W(AW), .PC_W(8), .RID_W(2), .LINE_BYTES(LINE), .ENTRIES(8),
    .WAYS(4), .DEGREE(DEG), .DISTANCE(DIST), .CONF_BITS(2), .THRESH_PCT(50), .USE_RID(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .train_valid(train_valid), .train_ready(train_ready),
    .train_pc(train_pc), .train_rid(train_rid), .train_addr(train_addr),
    .pf_valid(pf_valid), .pf_ready(pf_ready), .pf_addr(pf_addr));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int eff_of(input int s);
    if (s > -LINE && s < LINE) return (s < 0) ? -LINE : LINE;
    return s;
  endfunction

  task automatic do_reset();
    rst_n = 0; train_valid = 0; pf_ready = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(pf_valid == 0, "R1 pf_valid", int'(pf_valid), 0);
    chk(train_ready == 1, "R1 train_ready", int'(train_ready), 1);
  endtask

  task automatic do_train(input logic [7:0] pc, input logic [1:0] rid, input logic [AW-1:0] addr,
                          input int n, input int eff, input bit junk, input string req);
    int got = 0, guard = 0;
    chk(train_ready == 1, "R9 ready before access", int'(train_ready), 1);
    train_valid = 1; train_pc = pc; train_rid = rid; train_addr = addr;
    @(negedge clk);
    train_valid = 0;
    if (n == 0) chk(pf_valid == 0, req, int'(pf_valid), 0);
    while (got < n && guard < 100) begin
      logic [AW-1:0] expa;
      bit rdy;
      guard++;
      rdy = (pat % 5 != 1) && (pat % 5 != 2);
      pat++;
      expa = 16'(int'(addr) + (DIST + got + 1) * eff) & 16'hFFF0;
      chk(pf_valid == 1, req, int'(pf_valid), 1);
      chk(pf_addr == expa, req, int'(pf_addr), int'(expa));
      chk(train_ready == 0, "R9 ready low in burst", int'(train_ready), 0);
      if (junk) begin
        train_valid = !(rdy && got == n - 1);
        train_pc = pc; train_rid = rid; train_addr = 16'h1234;
      end
      pf_ready = rdy;
      @(negedge clk);
      if (rdy) got++;
    end
    pf_ready = 0; train_valid = 0;
    if (n > 0) begin
      chk(pf_valid == 0, "R8 burst length", int'(pf_valid), 0);
      chk(train_ready == 1, "R9 ready after burst", int'(train_ready), 1);
    end
  endtask

  task automatic run_stream(input logic [7:0] pc, input logic [AW-1:0] a0, input int s);
    for (int j = 0; j <= 5; j++) begin
      logic [AW-1:0] a;
      int n;
      string req;
      a = 16'(int'(a0) + j * s);
      n = (s != 0 && j >= 3) ? DEG : 0;
      if (s == 0) req = "R5 zero stride";
      else if (j == 0) req = "R3 miss";
      else if (j < 3) req = "R2 below threshold";
      else if (j == 5) req = "R9 ignored access";
      else if (s > -LINE && s < LINE) req = "R6 rounded stride";
      else req = "R7 burst address";
      do_train(pc, 2'd1, a, n, (s == 0) ? 0 : eff_of(s), j == 4, req);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int pc;
    do_reset();
    pc = 1;
    for (int s = -40; s <= 40; s += 3) begin
      run_stream(8'(pc), 16'h8003 + 16'(pc * 37), s);
      pc++;
    end
    run_stream(8'(pc), 16'h4000, 0);   pc++;
    run_stream(8'(pc), 16'h4008, 16);  pc++;
    run_stream(8'(pc), 16'h4008, -16); pc++;
    run_stream(8'(pc), 16'h4008, -17); pc++;
    run_stream(8'(pc), 16'h4008, 15);  pc++;
    run_stream(8'(pc), 16'h0030, -16); pc++;

    // R4: stride change after full confidence
    do_reset();
    for (int j = 0; j <= 4; j++)
      do_train(8'h21, 2'd0, 16'(16'h2000 + j * 32), (j >= 3) ? DEG : 0, 32, 0, "R4 ramp");
    do_train(8'h21, 2'd0, 16'h2080 - 16'd48, DEG, -48, 0, "R4 new stride fires");
    do_train(8'h21, 2'd0, 16'h2050 + 16'd20, 0, 0, 0, "R4 decrement below threshold");
    do_train(8'h21, 2'd0, 16'h2064 + 16'd20, DEG, 20, 0, "R4 recovered");

    // R10: requestor identifier is part of the key
    do_reset();
    for (int j = 0; j <= 3; j++)
      do_train(8'h33, 2'd1, 16'(16'h3000 + j * 64), (j == 3) ? DEG : 0, 64, 0, "R10 ramp");
    do_train(8'h33, 2'd2, 16'h3100, 0, 0, 0, "R10 other rid misses");
    do_train(8'h33, 2'd1, 16'h3100, DEG, 64, 0, "R10 own entry kept");

    // R11: tree pseudo-LRU eviction in set 0
    do_reset();
    for (int j = 0; j <= 3; j++)
      do_train(8'h10, 2'd0, 16'(16'h5000 + j * 32), (j == 3) ? DEG : 0, 32, 0, "R11 train victim");
    do_train(8'h12, 2'd0, 16'h6000, 0, 0, 0, "R11 fill way1");
    do_train(8'h14, 2'd0, 16'h6100, 0, 0, 0, "R11 fill way2");
    do_train(8'h16, 2'd0, 16'h6200, 0, 0, 0, "R11 fill way3");
    do_train(8'h11, 2'd0, 16'h7000, 0, 0, 0, "R11 other set");
    do_train(8'h18, 2'd0, 16'h6300, 0, 0, 0, "R11 evicting alloc");
    do_train(8'h10, 2'd0, 16'h5080, 0, 0, 0, "R11 evicted entry misses");
    do_train(8'h10, 2'd0, 16'h50A0, 0, 0, 0, "R11 reallocated zero stride");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule